// File: doc/BRIEF.md
# Pipeline Hazard and Bypass Controller

This block is the data-hazard control for a five-stage in-order integer pipeline (fetch, decode, execute, memory, writeback). Each cycle it takes the instruction sitting in decode: its validity, its source register numbers and whether each source is really read, and its destination, write flag and load flag. It keeps its own record of which destination registers are pending in the execute and memory stages. It compares the decode sources against that record. From the comparison it drives a combinational `stall` that freezes fetch and decode and puts a no-op into execute. It also drives one registered bypass select per ALU operand, which is valid during the consumer's execute cycle.

A static input `fwd_en` picks the policy. With `fwd_en` low the block only interlocks: a consumer waits in decode until its producer reaches writeback. The register file writes first and reads second within a cycle, so the consumer then reads the new value. With `fwd_en` high, ALU results are bypassed from the execute/memory register with no stall. A load followed at once by a user of its result still costs one bubble, after which the loaded value comes from the memory/writeback register. Operand B also carries store data, and it is checked the same way as operand A.

Top module: `pipe_hazard_ctl`

## Requirements
- R1: Through reset, and in the first cycle after it, `stall` is 0 and both selects are 00 (register file).
- R2: With `fwd_en`=0, a used source that matches a writing instruction in execute or memory raises `stall`. An instruction that depends on the one just ahead of it therefore waits exactly 2 cycles, and in this mode both selects always stay 00.
- R3: With `fwd_en`=1, a used source that matches a non-load writer in execute causes no stall. In the consumer's next cycle, its select is 10 (execute/memory bypass).
- R4: With `fwd_en`=1, a used source that matches a writer in memory, and not one in execute, gives select 01 (memory/writeback bypass) in the next cycle.
- R5: With `fwd_en`=1, a used source that matches a load in execute raises `stall` for exactly one cycle. After that cycle the consumer gets select 01.
- R6: When both the execute and the memory entries match an operand, the younger one wins: the select is 10.
- R7: Register 0 never causes a stall or a bypass. A source flagged as unused, or a decode slot marked invalid, causes neither.
- R8: A producer that has reached writeback when its consumer is in decode causes no stall, and the select is 00.
- R9: A cycle with `stall` high puts a no-op into execute. That no-op writes nothing and later causes no hazard, and both selects are 00 in the following cycle.
- R10: Select encoding per operand: 00 register file, 10 execute/memory bypass, 01 memory/writeback bypass. The value 11 never appears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fwd_en | input | 1 | Policy: 0 interlock only, 1 bypass with load-use bubble |
| id_valid | input | 1 | Decode slot holds a real instruction |
| id_rs1 | input | 5 | Source register of operand A |
| id_use1 | input | 1 | Operand A source is read |
| id_rs2 | input | 5 | Source register of operand B or store data |
| id_use2 | input | 1 | Operand B source is read |
| id_rd | input | 5 | Destination register |
| id_wr | input | 1 | Instruction writes its destination |
| id_load | input | 1 | Instruction is a load |
| stall | output | 1 | Freeze fetch/decode, send a no-op to execute |
| sel_a | output | 2 | Operand A bypass select, valid in execute |
| sel_b | output | 2 | Operand B bypass select, valid in execute |

## Verification
Directed sequences place one producer at distances of one, two and three instructions ahead of its consumer, under each policy. The stall count and the select then separate the execute-match, memory-match and writeback-match paths. A load-then-use pair separates the single load bubble from the two-cycle interlock. A double match on the same register exposes the priority, and register 0, unused sources and invalid slots show that each is masked. Random instruction streams with a small register range, so that dependencies are frequent, are checked in both modes against a reference model of the stage record.

// File: rtl/phc_pkg.sv
package phc_pkg;
  localparam int REG_AW = 5;
  localparam int TRACK_DEPTH = 2;

  typedef struct packed {
    logic              wr;
    logic              ld;
    logic [REG_AW-1:0] rd;
  } dst_t;

  typedef enum logic [1:0] {
    SEL_RF    = 2'b00,
    SEL_MEMWB = 2'b01,
    SEL_EXMEM = 2'b10
  } byp_t;
endpackage

// File: rtl/hz_track.sv
module hz_track
  import phc_pkg::*;
#(
  parameter int DEPTH = TRACK_DEPTH
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              stall,
  input  logic              id_valid,
  input  logic              id_wr,
  input  logic              id_ld,
  input  logic [REG_AW-1:0] id_rd,
  output dst_t              ex_o,
  output dst_t              mem_o
);
  dst_t stage_q [DEPTH];
  dst_t entry_in;

  always_comb begin
    entry_in = '0;
    if (id_valid && !stall && id_wr) begin
      entry_in.wr = 1'b1;
      entry_in.ld = id_ld;
      entry_in.rd = id_rd;
    end
  end

  generate
    for (genvar s = 0; s < DEPTH; s++) begin : g_stage
      always_ff @(posedge clk) begin
        if (rst) stage_q[s] <= '0;
        else if (s == 0) stage_q[s] <= entry_in;
        else stage_q[s] <= stage_q[s-1];
      end
    end
  endgenerate

  assign ex_o  = stage_q[0];
  assign mem_o = stage_q[1];

  // R9
  bubble_nowrite_chk: assert property (@(posedge clk) disable iff (rst)
    stall |=> !ex_o.wr);
endmodule

// File: rtl/hz_cmp.sv
module hz_cmp
  import phc_pkg::*;
(
  input  logic              fwd_en,
  input  logic              use_i,
  input  logic [REG_AW-1:0] rs_i,
  input  dst_t              ex_i,
  input  dst_t              mem_i,
  output logic              stall_o,
  output byp_t              sel_o
);
  logic live, hit_ex, hit_mem;

  assign live    = use_i && (rs_i != '0);
  assign hit_ex  = live && ex_i.wr  && (ex_i.rd  == rs_i);
  assign hit_mem = live && mem_i.wr && (mem_i.rd == rs_i);

  always_comb begin
    if (fwd_en) stall_o = hit_ex && ex_i.ld;
    else        stall_o = hit_ex || hit_mem;

    if (!fwd_en)      sel_o = SEL_RF;
    else if (hit_ex)  sel_o = SEL_EXMEM;
    else if (hit_mem) sel_o = SEL_MEMWB;
    else              sel_o = SEL_RF;
  end
endmodule

// File: rtl/pipe_hazard_ctl.sv
module pipe_hazard_ctl
  import phc_pkg::*;
#(
  parameter int N_OPS = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              fwd_en,
  input  logic              id_valid,
  input  logic [REG_AW-1:0] id_rs1,
  input  logic              id_use1,
  input  logic [REG_AW-1:0] id_rs2,
  input  logic              id_use2,
  input  logic [REG_AW-1:0] id_rd,
  input  logic              id_wr,
  input  logic              id_load,
  output logic              stall,
  output logic [1:0]        sel_a,
  output logic [1:0]        sel_b
);
  dst_t ex_e, mem_e;
  logic [REG_AW-1:0] rs_v  [N_OPS];
  logic              use_v [N_OPS];
  logic [N_OPS-1:0]  op_stall;
  byp_t              sel_c [N_OPS];
  byp_t              sel_q [N_OPS];

  assign rs_v[0]  = id_rs1;
  assign rs_v[1]  = id_rs2;
  assign use_v[0] = id_use1 && id_valid;
  assign use_v[1] = id_use2 && id_valid;

  hz_track u_track (
    .clk(clk), .rst(rst), .stall(stall), .id_valid(id_valid),
    .id_wr(id_wr), .id_ld(id_load), .id_rd(id_rd),
    .ex_o(ex_e), .mem_o(mem_e)
  );

  generate
    for (genvar i = 0; i < N_OPS; i++) begin : g_op
      hz_cmp u_cmp (
        .fwd_en(fwd_en), .use_i(use_v[i]), .rs_i(rs_v[i]),
        .ex_i(ex_e), .mem_i(mem_e),
        .stall_o(op_stall[i]), .sel_o(sel_c[i])
      );
      always_ff @(posedge clk) begin
        if (rst || stall) sel_q[i] <= SEL_RF;
        else              sel_q[i] <= sel_c[i];
      end
    end
  endgenerate

  assign stall = |op_stall;
  assign sel_a = sel_q[0];
  assign sel_b = sel_q[1];

  // R2
  interlock_nosel_chk: assert property (@(posedge clk) disable iff (rst)
    !fwd_en |-> (sel_a == 2'b00 && sel_b == 2'b00));
  // R5
  load_single_bubble_chk: assert property (@(posedge clk) disable iff (rst)
    (fwd_en && stall) |=> !stall);
  // R7
  invalid_nostall_chk: assert property (@(posedge clk) disable iff (rst)
    !id_valid |-> !stall);
  // R10
  sel_code_chk: assert property (@(posedge clk) disable iff (rst)
    sel_a != 2'b11 && sel_b != 2'b11);
  // R9
  stall_selclr_chk: assert property (@(posedge clk) disable iff (rst)
    stall |=> (sel_a == 2'b00 && sel_b == 2'b00));
endmodule

// File: tb/sim_pipe_hazard_ctl.sv
`timescale 1ns/1ps
module sim_pipe_hazard_ctl;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic fwd_en = 1'b0;
  logic id_valid = 1'b0, id_use1 = 1'b0, id_use2 = 1'b0;
  logic id_wr = 1'b0, id_load = 1'b0;
  logic [4:0] id_rs1 = '0, id_rs2 = '0, id_rd = '0;
  logic stall;
  logic [1:0] sel_a, sel_b;

  always #2.5 clk = ~clk;

  pipe_hazard_ctl u0 (
    .clk(clk), .rst(rst), .fwd_en(fwd_en), .id_valid(id_valid),
    .id_rs1(id_rs1), .id_use1(id_use1), .id_rs2(id_rs2), .id_use2(id_use2),
    .id_rd(id_rd), .id_wr(id_wr), .id_load(id_load),
    .stall(stall), .sel_a(sel_a), .sel_b(sel_b)
  );

  int n_vec = 0, n_bad = 0;
  bit   m_wr [2];
  bit   m_ld [2];
  logic [4:0] m_rd [2];
  logic [1:0] exp_a = 2'b00, exp_b = 2'b00;

  task automatic chk(input logic [1:0] act, input logic [1:0] exp, input string tag, input string what);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %b expected %b", tag, what, act, exp);
    end
  endtask

  function automatic bit hit(int s, logic [4:0] rs, bit u);
    return u && rs != 0 && m_wr[s] && m_rd[s] == rs;
  endfunction

  function automatic bit op_st(logic [4:0] rs, bit u);
    if (fwd_en) return hit(0, rs, u) && m_ld[0];
    return hit(0, rs, u) || hit(1, rs, u);
  endfunction

  function automatic logic [1:0] op_sel(logic [4:0] rs, bit u);
    if (!fwd_en) return 2'b00;
    if (hit(0, rs, u)) return 2'b10;
    if (hit(1, rs, u)) return 2'b01;
    return 2'b00;
  endfunction

  task automatic do_reset(input bit mode);
    rst = 1'b1; fwd_en = mode; id_valid = 1'b0;
    repeat (3) @(negedge clk);
    #1;
    chk({1'b0, stall}, 2'b00, "R1", "stall in reset");
    chk(sel_a, 2'b00, "R1", "sel_a in reset");
    rst = 1'b0;
    for (int s = 0; s < 2; s++) begin m_wr[s] = 0; m_ld[s] = 0; m_rd[s] = 0; end
    exp_a = 2'b00; exp_b = 2'b00;
    @(negedge clk);
  endtask

  task automatic step(input bit v, input logic [4:0] r1, input bit u1,
                      input logic [4:0] r2, input bit u2, input logic [4:0] rd,
                      input bit w, input bit ld, input string tag, output bit st);
    bit es;
    chk(sel_a, exp_a, tag, "sel_a");
    chk(sel_b, exp_b, tag, "sel_b");
    id_valid = v; id_rs1 = r1; id_use1 = u1; id_rs2 = r2; id_use2 = u2;
    id_rd = rd; id_wr = w; id_load = ld;
    #1;
    es = op_st(r1, u1 && v) || op_st(r2, u2 && v);
    chk({1'b0, stall}, {1'b0, es}, tag, "stall");
    exp_a = es ? 2'b00 : op_sel(r1, u1 && v);
    exp_b = es ? 2'b00 : op_sel(r2, u2 && v);
    m_wr[1] = m_wr[0]; m_ld[1] = m_ld[0]; m_rd[1] = m_rd[0];
    m_wr[0] = v && !es && w; m_ld[0] = ld; m_rd[0] = rd;
    st = es;
    @(negedge clk);
  endtask

  task automatic issue(input logic [4:0] r1, input bit u1, input logic [4:0] r2,
                       input bit u2, input logic [4:0] rd, input bit w, input bit ld,
                       input string tag, output int bub);
    bit st;
    bub = 0;
    do begin
      step(1'b1, r1, u1, r2, u2, rd, w, ld, tag, st);
      if (st) bub++;
    end while (st && bub < 10);
  endtask

  task automatic expect_sel(input logic [1:0] a, input logic [1:0] b, input string tag);
    chk(sel_a, a, tag, "sel_a direct");
    chk(sel_b, b, tag, "sel_b direct");
  endtask

  task automatic run_random(input int count);
    bit st = 0;
    bit v, u1, u2, w, ld;
    logic [4:0] r1, r2, rd;
    for (int k = 0; k < count; k++) begin
      if (!st) begin
        v = ($urandom % 8) != 0; u1 = $urandom % 2; u2 = $urandom % 2;
        r1 = $urandom % 6; r2 = $urandom % 6; rd = $urandom % 6;
        w = ($urandom % 4) != 0; ld = $urandom % 2;
      end
      step(v, r1, u1, r2, u2, rd, w, ld, "random R2/R3/R4/R5/R6/R7", st);
    end
  endtask

  initial begin
    int b;
    void'($urandom(32'd4711));
    // interlock mode
    do_reset(1'b0);
    issue(1, 1, 2, 1, 3, 1, 0, "R1", b);
    expect_sel(2'b00, 2'b00, "R1");
    issue(3, 1, 0, 0, 4, 1, 0, "R2", b);
    chk(b[1:0], 2'd2, "R2", "bubbles after ALU producer");
    issue(1, 0, 0, 0, 5, 1, 1, "R2", b);
    issue(0, 0, 5, 1, 0, 0, 0, "R2", b);
    chk(b[1:0], 2'd2, "R2", "bubbles store data after load");
    // bypass mode
    do_reset(1'b1);
    issue(1, 1, 2, 1, 3, 1, 0, "R3", b);
    issue(3, 1, 0, 0, 9, 1, 0, "R3", b);
    chk(b[1:0], 2'd0, "R3", "bubbles ALU bypass");
    expect_sel(2'b10, 2'b00, "R3");
    issue(1, 1, 0, 0, 4, 1, 0, "R4", b);
    issue(1, 1, 0, 0, 10, 1, 0, "R4", b);
    issue(0, 0, 4, 1, 0, 0, 0, "R4", b);
    expect_sel(2'b00, 2'b01, "R4");
    issue(1, 0, 0, 0, 6, 1, 1, "R5", b);
    issue(6, 1, 0, 0, 11, 1, 0, "R5", b);
    chk(b[1:0], 2'd1, "R5", "load-use bubbles");
    expect_sel(2'b01, 2'b00, "R5");
    issue(1, 1, 0, 0, 7, 1, 0, "R6", b);
    issue(1, 1, 0, 0, 7, 1, 0, "R6", b);
    issue(7, 1, 7, 1, 12, 1, 0, "R6", b);
    expect_sel(2'b10, 2'b10, "R6");
    issue(1, 1, 0, 0, 0, 1, 1, "R7", b);
    issue(0, 1, 0, 1, 13, 1, 0, "R7", b);
    chk(b[1:0], 2'd0, "R7", "x0 bubbles");
    expect_sel(2'b00, 2'b00, "R7");
    issue(1, 0, 0, 0, 14, 1, 1, "R7", b);
    issue(14, 0, 14, 0, 15, 1, 0, "R7", b);
    chk(b[1:0], 2'd0, "R7", "unused source bubbles");
    issue(1, 0, 0, 0, 16, 1, 1, "R7", b);
    begin
      bit st;
      step(1'b0, 16, 1, 16, 1, 17, 1, 0, "R7 invalid slot", st);
      chk({1'b0, st}, 2'b00, "R7", "invalid slot stall");
    end
    issue(1, 1, 0, 0, 9, 1, 0, "R8", b);
    issue(1, 1, 0, 0, 18, 1, 0, "R8", b);
    issue(1, 1, 0, 0, 19, 1, 0, "R8", b);
    issue(9, 1, 0, 0, 20, 1, 0, "R8", b);
    chk(b[1:0], 2'd0, "R8", "writeback distance bubbles");
    expect_sel(2'b00, 2'b00, "R8");
    // R9: bubble behind a load-use stall creates no later hazard
    issue(1, 0, 0, 0, 21, 1, 1, "R9", b);
    issue(21, 1, 0, 0, 22, 1, 0, "R9", b);
    expect_sel(2'b01, 2'b00, "R9");
    run_random(3000);
    do_reset(1'b0);
    run_random(3000);
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    #(200000 * 5);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule